// File: doc/BRIEF.md
# Pin Routing Matrix

This block is a register-programmed crossbar between a pool of on-chip audio peripherals and a bank of shared external pins. The peripherals are serial ports, an input data port, precision clock generators, timers, sample rate converters and SPI. Each pin has its own configuration word with two independent 5-bit selects. One picks the peripheral output that becomes the pin's driven value. The other picks the peripheral signal that becomes the pin's output enable. Code 0 in either select means constant low. Any code above the size of the matching source pool also routes constant low, but it is still stored.

Every pin's sampled pad value goes back to the peripheral side on every cycle, whatever the pin's output enable. A separate register holds one pull-up enable bit per pin. These bits are all set by reset, and software can clear them one by one. All of the state sits behind a simple 32-bit address/data port. Writes take one clock, and reads return the addressed register combinationally.

Top module: `pin_route_matrix`

## Requirements
- R1: After reset, every pin's data select and enable select are 0, `pin_out` and `pin_oe` are all zero, and `pin_pu` is all ones.
- R2: A data select code k with 1 <= k <= NUM_DSRC drives `pin_out[p]` with `src_data[k-1]`.
- R3: A data select code of 0 or above NUM_DSRC drives `pin_out[p]` low, and the stored code still reads back unchanged.
- R4: An enable select code k with 1 <= k <= NUM_ESRC drives `pin_oe[p]` with `src_en[k-1]`. Code 0 or a code above NUM_ESRC drives it low.
- R5: The data and enable selects of a pin are independent. Writing a pin affects only that pin's outputs.
- R6: Pin p's configuration word is at byte address 4*p. Bits [4:0] hold the data select and bits [12:8] hold the enable select. All other bits are ignored on write and read as 0.
- R7: The pull-up word is at byte address 4*NUM_PINS (0x50 by default). Bit p is pin p's pull-up enable, shown on `pin_pu[p]`. Bits above NUM_PINS read as 0.
- R8: `periph_pin_in` equals `pin_in` in the same cycle, regardless of any output enable.
- R9: A write changes the outputs only after the clock edge that accepts it, and from that edge on.
- R10: Writes to misaligned addresses or to addresses above the pull-up word change no state. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the configuration port |
| bus_addr | input | 32 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_data | input | NUM_DSRC | Peripheral output signals available as pin data |
| src_en | input | NUM_ESRC | Peripheral signals available as pin output enables |
| pin_in | input | NUM_PINS | Sampled pad values |
| pin_out | output | NUM_PINS | Routed pad drive values |
| pin_oe | output | NUM_PINS | Routed pad output enables |
| pin_pu | output | NUM_PINS | Per-pin pull-up enables |
| periph_pin_in | output | NUM_PINS | Pad values broadcast to peripheral inputs |

## Verification
A corrupted select code shows up on `pin_out` or `pin_oe` in the first cycle after the write edge. The bench varies the source vectors each cycle, so a pin that is tied to the wrong source soon disagrees with the model. The same corruption is visible on `bus_rdata` as soon as that word is addressed. A wrong address decode shows up as a pin, or the pull-up word, changing after a write aimed elsewhere. That change appears on the next full sweep of the outputs and the readback.

// File: rtl/pin_route_pkg.sv
`timescale 1ns/1ps
package pin_route_pkg;
    localparam int SEL_W  = 5;
    localparam int OE_LSB = 8;

    typedef struct packed {
        logic [SEL_W-1:0] oe_sel;
        logic [SEL_W-1:0] dat_sel;
    } pin_cfg_t;
endpackage

// File: rtl/xbar_pin_mux.sv
`timescale 1ns/1ps
module xbar_pin_mux
    import pin_route_pkg::*;
#(
    parameter int NUM_IN = 24
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_IN-1:0] src,
    output logic              y
);
    // Code 0 and codes beyond the pool leave y low.
    always_comb begin
        y = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (sel == SEL_W'(i + 1)) y = src[i];
        end
    end
endmodule

// File: rtl/xbar_cfg_regs.sv
`timescale 1ns/1ps
module xbar_cfg_regs
    import pin_route_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [31:0]                   bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output pin_cfg_t [NUM_PINS-1:0]       cfg_o,
    output logic [NUM_PINS-1:0]           pu_o
);
    localparam logic [31:0] PU_ADDR = 32'(4 * NUM_PINS);

    typedef struct packed {
        pin_cfg_t [NUM_PINS-1:0] cfg;
        logic [NUM_PINS-1:0]     pu;
    } regs_t;

    regs_t       r_d, r_q;
    logic [29:0] widx;
    logic        aligned;
    logic        unused_wdata;

    assign widx         = bus_addr[31:2];
    assign aligned      = (bus_addr[1:0] == 2'b00);
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        r_d       = r_q;
        bus_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (aligned && widx == 30'(p)) begin
                bus_rdata[SEL_W-1:0]       = r_q.cfg[p].dat_sel;
                bus_rdata[OE_LSB+:SEL_W]   = r_q.cfg[p].oe_sel;
                if (bus_wr) begin
                    r_d.cfg[p].dat_sel = bus_wdata[SEL_W-1:0];
                    r_d.cfg[p].oe_sel  = bus_wdata[OE_LSB+:SEL_W];
                end
            end
        end
        if (bus_addr == PU_ADDR) begin
            bus_rdata[NUM_PINS-1:0] = r_q.pu;
            if (bus_wr) r_d.pu = bus_wdata[NUM_PINS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg <= '0;
            r_q.pu  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_o = r_q.cfg;
    assign pu_o  = r_q.pu;

    // R1: pull-ups are all enabled in the first cycle out of reset
    a_r1_pu_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pu_o == '1));

    // R7: a pull-up write lands on the next edge
    a_r7_pu_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PU_ADDR) |=> (pu_o == $past(bus_wdata[NUM_PINS-1:0])));

    // R10: out-of-map or misaligned writes leave all state alone
    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr[1:0] != 2'b00 || bus_addr > PU_ADDR)) |=>
        ($stable(cfg_o) && $stable(pu_o)));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        // R6: field placement of a pin configuration write
        a_r6_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 32'(4 * p)) |=>
            (cfg_o[p].dat_sel == $past(bus_wdata[SEL_W-1:0]) &&
             cfg_o[p].oe_sel  == $past(bus_wdata[OE_LSB+:SEL_W])));
    end
endmodule

// File: rtl/pin_route_matrix.sv
`timescale 1ns/1ps
module pin_route_matrix
    import pin_route_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int NUM_DSRC = 24,
    parameter int NUM_ESRC = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [31:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_DSRC-1:0] src_data,
    input  logic [NUM_ESRC-1:0] src_en,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pu,
    output logic [NUM_PINS-1:0] periph_pin_in
);
    pin_cfg_t [NUM_PINS-1:0] cfg;

    xbar_cfg_regs #(.NUM_PINS(NUM_PINS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg),
        .pu_o      (pin_pu)
    );

    // Pad inputs reach the peripherals unconditionally.
    assign periph_pin_in = pin_in;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        xbar_pin_mux #(.NUM_IN(NUM_DSRC)) i_dat_mux (
            .sel (cfg[p].dat_sel),
            .src (src_data),
            .y   (pin_out[p])
        );
        xbar_pin_mux #(.NUM_IN(NUM_ESRC)) i_oe_mux (
            .sel (cfg[p].oe_sel),
            .src (src_en),
            .y   (pin_oe[p])
        );

        // R3: dead data codes hold the pin low
        a_r3_dead_dat_low: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[p].dat_sel == '0 || cfg[p].dat_sel > SEL_W'(NUM_DSRC)) |-> !pin_out[p]);

        // R4: dead enable codes keep the pin an input
        a_r4_dead_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[p].oe_sel == '0 || cfg[p].oe_sel > SEL_W'(NUM_ESRC)) |-> !pin_oe[p]);

        // R2: the lowest live code follows the first source
        a_r2_first_src: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[p].dat_sel == SEL_W'(1)) |-> (pin_out[p] == src_data[0]));
    end

    // R1: all pins are inputs in the first cycle out of reset
    a_r1_oe_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/test_pin_route_matrix.sv
`timescale 1ns/1ps
module test_pin_route_matrix;
    localparam int NP = 20;
    localparam int ND = 24;
    localparam int NE = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_wr;
    logic [31:0]   bus_addr, bus_wdata, bus_rdata;
    logic [ND-1:0] src_data;
    logic [NE-1:0] src_en;
    logic [NP-1:0] pin_in, pin_out, pin_oe, pin_pu, periph_pin_in;

    int checks = 0;
    int errors = 0;

    logic [4:0]    m_dat [NP];
    logic [4:0]    m_oe  [NP];
    logic [NP-1:0] m_pu;

    always #5 clk = ~clk;

    pin_route_matrix #(.NUM_PINS(NP), .NUM_DSRC(ND), .NUM_ESRC(NE)) i_pin_route_matrix (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_data(src_data),
        .src_en(src_en), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pu(pin_pu), .periph_pin_in(periph_pin_in)
    );

    function automatic logic pick(input logic [4:0] code, input logic [31:0] vec, input int n);
        int c = int'(code);
        if (c >= 1 && c <= n) return vec[c-1];
        return 1'b0;
    endfunction

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = pick(m_dat[p], 32'(src_data), ND);
        return r;
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = pick(m_oe[p], 32'(src_en), NE);
        return r;
    endfunction

    function automatic logic [31:0] exp_word(input int p);
        return (32'(m_oe[p]) << 8) | 32'(m_dat[p]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        if (addr[1:0] == 2'b00 && addr < 32'(4 * NP)) begin
            m_dat[int'(addr >> 2)] = data[4:0];
            m_oe[int'(addr >> 2)]  = data[12:8];
        end else if (addr == 32'(4 * NP)) begin
            m_pu = data[NP-1:0];
        end
    endtask

    task automatic rd(input logic [31:0] addr, output logic [31:0] data);
        bus_addr = addr;
        #1 data = bus_rdata;
    endtask

    task automatic chk_pins(input string req);
        #1;
        chk({req, " pin_out"}, 32'(pin_out), 32'(exp_out()));
        chk({req, " pin_oe"}, 32'(pin_oe), 32'(exp_oe()));
        chk({req, " pin_pu"}, 32'(pin_pu), 32'(m_pu));
        chk({req, " R8 periph_pin_in"}, 32'(periph_pin_in), 32'(pin_in));
    endtask

    task automatic chk_readback(input string req);
        logic [31:0] d;
        for (int p = 0; p < NP; p++) begin
            rd(32'(4 * p), d);
            chk(req, d, exp_word(p));
        end
        rd(32'(4 * NP), d);
        chk(req, d, 32'(m_pu));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        for (int p = 0; p < NP; p++) begin m_dat[p] = '0; m_oe[p] = '0; end
        m_pu = '1;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        src_data = '1; src_en = '1; pin_in = 20'h5A5A5;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 pin_oe", 32'(pin_oe), 32'h0);
        chk("R1 pin_out", 32'(pin_out), 32'h0);
        chk("R1 pin_pu", 32'(pin_pu), 32'h000F_FFFF);
        chk_readback("R1 readback");
        chk("R8 broadcast while all inputs", 32'(periph_pin_in), 32'h5A5A5);

        // R2 data routing at both ends of the pool
        src_data = 24'h800001;
        wr(32'd0, 32'd1);
        wr(32'(4 * 19), 32'd24);
        chk_pins("R2 ends");
        chk("R2 pin0 from src0", 32'(pin_out[0]), 32'd1);
        chk("R2 pin19 from src23", 32'(pin_out[19]), 32'd1);
        src_data = 24'h7FFFFE;
        chk_pins("R2 inverted sources");

        // R3 dead data codes, stored unchanged
        src_data = '1;
        wr(32'(4 * 5), 32'd25);
        wr(32'(4 * 6), 32'd31);
        chk("R3 code 25 low", 32'(pin_out[5]), 32'd0);
        chk("R3 code 31 low", 32'(pin_out[6]), 32'd0);
        rd(32'(4 * 5), d);
        chk("R3 readback 25", d, 32'd25);

        // R4 enable routing
        src_en = 24'h800000;
        wr(32'(4 * 7), 32'(24 << 8));
        chk("R4 enable code 24", 32'(pin_oe[7]), 32'd1);
        wr(32'(4 * 8), 32'(30 << 8));
        src_en = '1;
        chk_pins("R4 dead enable");
        chk("R4 enable code 30 low", 32'(pin_oe[8]), 32'd0);

        // R5 independent selects on one pin, neighbours untouched
        src_data = 24'h000004; src_en = 24'h000000;
        wr(32'(4 * 2), 32'((10 << 8) | 3));
        chk("R5 data from src2", 32'(pin_out[2]), 32'd1);
        chk("R5 enable from en9 low", 32'(pin_oe[2]), 32'd0);
        src_data = 24'h0; src_en = 24'h000200;
        #1;
        chk("R5 data now low", 32'(pin_out[2]), 32'd0);
        chk("R5 enable now high", 32'(pin_oe[2]), 32'd1);
        chk_pins("R5 whole bank");

        // R6 ignored bits
        wr(32'(4 * 11), 32'hFFFF_FFFF);
        rd(32'(4 * 11), d);
        chk("R6 masked readback", d, 32'h0000_1F1F);

        // R7 pull-up clearing
        wr(32'(4 * NP), 32'hFFF0_0F0F);
        chk("R7 pin_pu", 32'(pin_pu), 32'h0000_0F0F);
        rd(32'(4 * NP), d);
        chk("R7 readback", d, 32'h0000_0F0F);

        // R9 write timing: old value until the accepting edge
        src_data = 24'h000002;
        wr(32'(4 * 4), 32'd2);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 32'(4 * 4); bus_wdata = 32'd3;
        #2 chk("R9 before edge", 32'(pin_out[4]), 32'd1);
        @(posedge clk);
        #1 bus_wr = 1'b0;
        m_dat[4] = 5'd3; m_oe[4] = 5'd0;
        chk("R9 after edge", 32'(pin_out[4]), 32'd0);

        // R10 unmapped and misaligned writes
        wr(32'(4 * NP + 4), 32'hFFFF_FFFF);
        wr(32'h0000_0002, 32'h0000_1F1F);
        wr(32'h0000_1000, 32'h0000_0000);
        chk_readback("R10 state kept");
        chk_pins("R10 outputs kept");
        rd(32'(4 * NP + 4), d);
        chk("R10 unmapped read", d, 32'h0);
        rd(32'h0000_0001, d);
        chk("R10 misaligned read", d, 32'h0);

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int p = int'($urandom_range(NP, 0));
            logic [31:0] w = $urandom;
            wr(32'(4 * p), w);
            src_data = ND'($urandom);
            src_en   = NE'($urandom);
            pin_in   = NP'($urandom);
            chk_pins("R2 R4 R5 R8 random");
        end
        chk_readback("R3 R6 R7 random readback");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule